// File: doc/BRIEF.md
# Disk Write Gate Timing Sequencer

This block decides when a disk drive's combined write and erase head enable turns on and off around sector marks, and when the data serializer may emit flux transitions. Because the erase poles trail the write gap by a fixed stretch of media travel, the heads stay off for a guard time after the sector mark that starts a write. The shared enable then stays on for a guard time past the following mark, so that the erased band fully covers the written band. Data may only start once the gate has been on for a settling time. The last data bit is cut off at the next mark.

Software or a sector matcher raises a one-cycle write request. The request is held until a sector mark and is consumed by that mark. A request that is still pending when the current sector ends chains the next sector: the gate stays on through the boundary. The guard and settling times are given in microseconds together with the clock frequency in MHz, and the block turns them into cycle counts. With the defaults (125 MHz, 25 µs lead, 2 µs settle, 25 µs trail) these are 3125, 250 and 3125 cycles.

Top module: `wgate_seq`

## Requirements
- R1: A synchronous reset drives head_en_o, flux_ok_o and bit_go_o low at the first clock edge that samples rst_i high. It also discards a pending write request.
- R2: A one-cycle pulse on wr_req_i is held until a sector mark. A mark with no request pending or present leaves head_en_o low.
- R3: head_en_o (write and erase together) rises exactly LEAD cycles after the edge that samples the accepting mark, where LEAD = CLK_MHZ*LEAD_US.
- R4: flux_ok_o rises exactly SETTLE cycles after head_en_o rises, where SETTLE = CLK_MHZ*SETTLE_US. It is never high unless head_en_o has been high for at least SETTLE consecutive cycles.
- R5: flux_ok_o falls at the edge that samples the next sector mark.
- R6: With no request pending, head_en_o falls exactly TRAIL cycles after that mark, where TRAIL = CLK_MHZ*TRAIL_US.
- R7: A request that arrives after a mark has been sampled, whether while idle, during the lead window or while writing, has no effect until the following mark.
- R8: A request pending at the mark that ends a written sector keeps head_en_o high across the boundary. flux_ok_o returns LEAD+SETTLE cycles after that mark.
- R9: A sector mark that arrives while the lead window is counting restarts it, so head_en_o rises LEAD cycles after the latest mark.
- R10: bit_go_o is high for one cycle after each edge that samples bit_stb_i high while flux_ok_o is high and mark_i is low. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mark_i | input | 1 | Sector mark, one-cycle pulse |
| wr_req_i | input | 1 | Write request for the next sector, one-cycle pulse |
| bit_stb_i | input | 1 | Serializer strobe asking to emit one flux bit cell |
| head_en_o | output | 1 | Combined write-gate and erase-current enable |
| flux_ok_o | output | 1 | Flux transitions may be emitted |
| bit_go_o | output | 1 | Qualified bit strobe to the encoder |

## Verification
Several properties are checked on every cycle. The first is the gate-before-data ordering and the minimum continuous gate time before data. The checks also cover the exact lead and trail distances from the latest mark, the loss of data permission at a mark, the qualification of bit strobes, and the reset clearing. Request holding, chaining of consecutive sectors and a mark that restarts the lead window are not visible to a per-cycle property. Only the bench's scenarios can show these, because they compare every edge of the two enables against scheduled times. A discarded request after reset is also shown only by the scenarios.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_WRITE = 3'd2,
    ST_TRAIL = 3'd3,
    ST_CHAIN = 3'd4
  } gs_state_e;

  function automatic int us_to_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gs_span_counter.sv
`timescale 1ns/1ps
// Saturating up-counter; hit flags the last cycle of a span of term_m1+1 cycles.
module gs_span_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] term_m1_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == term_m1_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q <= '0;
    end else if (en_i && !hit_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gs_req_latch.sv
`timescale 1ns/1ps
// Holds a write request pulse until a sector mark consumes it.
module gs_req_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic take_i,
  output logic live_o
);
  logic pend_q;

  assign live_o = pend_q | req_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || take_i) begin
      pend_q <= 1'b0;
    end else if (req_i) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gs_phase_ctrl.sv
`timescale 1ns/1ps
// Sector phase state machine with registered head enable, data permit and bit strobe.
module gs_phase_ctrl
  import gs_pkg::*;
#(
  parameter int PH_W = 12
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mark_i,
  input  logic req_live_i,
  input  logic bit_stb_i,
  input  logic ph_hit_i,
  input  logic st_hit_i,
  output logic take_o,
  output logic ph_en_o,
  output logic ph_sel_trail_o,
  output logic st_clr_o,
  output logic st_en_o,
  output logic head_en_o,
  output logic flux_ok_o,
  output logic bit_go_o
);
  gs_state_e state_q, state_n;
  logic      head_q, permit_q, go_q;
  logic      can_take;

  assign can_take = (state_q == ST_IDLE) || (state_q == ST_WRITE) || (state_q == ST_TRAIL);
  assign take_o   = mark_i && req_live_i && can_take;

  assign ph_en_o        = (state_q == ST_LEAD) || (state_q == ST_CHAIN) || (state_q == ST_TRAIL);
  assign ph_sel_trail_o = (state_q == ST_TRAIL);
  assign st_en_o        = (state_q == ST_WRITE);
  assign st_clr_o       = (state_q != ST_WRITE) || mark_i;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_o) state_n = ST_LEAD;
      ST_LEAD:  if (!mark_i && ph_hit_i) state_n = ST_WRITE;
      ST_WRITE: if (mark_i) state_n = take_o ? ST_CHAIN : ST_TRAIL;
      ST_TRAIL: begin
        if (take_o) state_n = ST_CHAIN;
        else if (!mark_i && ph_hit_i) state_n = ST_IDLE;
      end
      ST_CHAIN: if (!mark_i && ph_hit_i) state_n = ST_WRITE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      head_q   <= 1'b0;
      permit_q <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      state_q  <= state_n;
      head_q   <= (state_n == ST_WRITE) || (state_n == ST_TRAIL) || (state_n == ST_CHAIN);
      permit_q <= (state_q == ST_WRITE) && !mark_i && st_hit_i;
      go_q     <= bit_stb_i && permit_q && !mark_i;
    end
  end

  assign head_en_o = head_q;
  assign flux_ok_o = permit_q;
  assign bit_go_o  = go_q;
endmodule

// File: rtl/wgate_seq.sv
`timescale 1ns/1ps
module wgate_seq
  import gs_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int LEAD_US   = 25,
  parameter int SETTLE_US = 2,
  parameter int TRAIL_US  = 25
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mark_i,
  input  logic wr_req_i,
  input  logic bit_stb_i,
  output logic head_en_o,
  output logic flux_ok_o,
  output logic bit_go_o
);
  localparam int LEAD_CYC   = us_to_cycles(CLK_MHZ, LEAD_US);
  localparam int SETTLE_CYC = us_to_cycles(CLK_MHZ, SETTLE_US);
  localparam int TRAIL_CYC  = us_to_cycles(CLK_MHZ, TRAIL_US);
  localparam int PH_MAX     = max2(LEAD_CYC, TRAIL_CYC);
  localparam int PH_W       = $clog2(PH_MAX + 1);
  localparam int ST_W       = $clog2(SETTLE_CYC + 1);
  localparam logic [PH_W-1:0] LEAD_M1  = PH_W'(LEAD_CYC - 1);
  localparam logic [PH_W-1:0] TRAIL_M1 = PH_W'(TRAIL_CYC - 1);
  localparam logic [ST_W-1:0] SET_M1   = ST_W'(SETTLE_CYC - 1);

  logic req_live, take;
  logic ph_en, ph_sel_trail, ph_hit;
  logic st_clr, st_en, st_hit;
  logic [PH_W-1:0] ph_term;

  assign ph_term = ph_sel_trail ? TRAIL_M1 : LEAD_M1;

  gs_req_latch u_req (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (wr_req_i),
    .take_i (take),
    .live_o (req_live)
  );

  gs_span_counter #(.W(PH_W)) u_phase_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clr_i     (mark_i),
    .en_i      (ph_en),
    .term_m1_i (ph_term),
    .hit_o     (ph_hit)
  );

  gs_span_counter #(.W(ST_W)) u_settle_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .clr_i     (st_clr),
    .en_i      (st_en),
    .term_m1_i (SET_M1),
    .hit_o     (st_hit)
  );

  gs_phase_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .mark_i         (mark_i),
    .req_live_i     (req_live),
    .bit_stb_i      (bit_stb_i),
    .ph_hit_i       (ph_hit),
    .st_hit_i       (st_hit),
    .take_o         (take),
    .ph_en_o        (ph_en),
    .ph_sel_trail_o (ph_sel_trail),
    .st_clr_o       (st_clr),
    .st_en_o        (st_en),
    .head_en_o      (head_en_o),
    .flux_ok_o      (flux_ok_o),
    .bit_go_o       (bit_go_o)
  );
endmodule

// File: rtl/wgate_seq_chk.sv
`timescale 1ns/1ps
module wgate_seq_chk #(
  parameter int LEAD_CYC   = 3125,
  parameter int SETTLE_CYC = 250,
  parameter int TRAIL_CYC  = 3125
) (
  input logic clk_i,
  input logic rst_i,
  input logic mark_i,
  input logic bit_stb_i,
  input logic head_en_o,
  input logic flux_ok_o,
  input logic bit_go_o
);
  localparam int MAXV = (LEAD_CYC > TRAIL_CYC) ? ((LEAD_CYC > SETTLE_CYC) ? LEAD_CYC : SETTLE_CYC)
                                               : ((TRAIL_CYC > SETTLE_CYC) ? TRAIL_CYC : SETTLE_CYC);
  localparam int CW = $clog2(MAXV + 2) + 1;

  logic [CW-1:0] since_mark, gate_run;

  // cycles since the last sampled mark, and consecutive cycles of gate high
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      since_mark <= '0;
      gate_run   <= '0;
    end else begin
      if (mark_i) since_mark <= '0;
      else if (since_mark != '1) since_mark <= since_mark + 1'b1;
      if (!head_en_o) gate_run <= '0;
      else if (gate_run != '1) gate_run <= gate_run + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!head_en_o && !flux_ok_o && !bit_go_o));

  a_r4_permit_needs_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    flux_ok_o |-> head_en_o);

  a_r4_settle_time: assert property (@(posedge clk_i) disable iff (rst_i)
    flux_ok_o |-> (gate_run >= CW'(SETTLE_CYC)));

  a_r3_lead_distance: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(head_en_o) |-> (since_mark == CW'(LEAD_CYC)));

  a_r6_trail_distance: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(head_en_o) && !$past(rst_i)) |-> (since_mark == CW'(TRAIL_CYC)));

  a_r5_mark_stops_data: assert property (@(posedge clk_i) disable iff (rst_i)
    mark_i |=> !flux_ok_o);

  a_r10_bit_qualified: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_go_o |-> ($past(bit_stb_i) && $past(flux_ok_o) && !$past(mark_i)));
endmodule

bind wgate_seq wgate_seq_chk #(
  .LEAD_CYC   (LEAD_CYC),
  .SETTLE_CYC (SETTLE_CYC),
  .TRAIL_CYC  (TRAIL_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .mark_i    (mark_i),
  .bit_stb_i (bit_stb_i),
  .head_en_o (head_en_o),
  .flux_ok_o (flux_ok_o),
  .bit_go_o  (bit_go_o)
);

// File: tb/test_wgate_seq.sv
`timescale 1ns/1ps
module test_wgate_seq;
  // model clock 125 MHz; delays in cycles from the microsecond figures
  localparam int L = 125 * 25;
  localparam int S = 125 * 2;
  localparam int T = 125 * 25;
  localparam int P = 7000;  // sector period in cycles
  localparam int K_GON = 0, K_PON = 1, K_POFF = 2, K_GOFF = 3;

  logic clk = 1'b0, rst = 1'b1, mark = 1'b0, req = 1'b0, stb = 1'b0;
  logic head_en, flux_ok, bit_go;
  int pcnt = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_tag[$];
  logic  prev_g = 1'b0, prev_p = 1'b0;

  wgate_seq i_wgate_seq (
    .clk_i(clk), .rst_i(rst), .mark_i(mark), .wr_req_i(req), .bit_stb_i(stb),
    .head_en_o(head_en), .flux_ok_o(flux_ok), .bit_go_o(bit_go)
  );

  always #4 clk = ~clk;
  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, pcnt, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int cyc, input string tag);
    exp_kind.push_back(kind);
    exp_cyc.push_back(cyc);
    exp_tag.push_back(tag);
  endtask

  task automatic seen(input int kind);
    checks++;
    if (exp_kind.size() == 0) begin
      fails++;
      $display("FAIL unexpected edge kind %0d at cycle %0d: actual edge expected none (R2/R7)", kind, pcnt);
    end else begin
      if (exp_kind[0] != kind || exp_cyc[0] != pcnt) begin
        fails++;
        $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 exp_tag[0], kind, pcnt, exp_kind[0], exp_cyc[0]);
      end
      void'(exp_kind.pop_front());
      void'(exp_cyc.pop_front());
      void'(exp_tag.pop_front());
    end
  endtask

  // monitor: compares every enable edge with the scoreboard queue
  always @(negedge clk) begin
    if (pcnt >= 2) begin
      if (exp_cyc.size() != 0 && exp_cyc[0] < pcnt) begin
        checks++; fails++;
        $display("FAIL %s missed: actual none expected kind %0d at cycle %0d",
                 exp_tag[0], exp_kind[0], exp_cyc[0]);
        void'(exp_kind.pop_front());
        void'(exp_cyc.pop_front());
        void'(exp_tag.pop_front());
      end
      if (flux_ok != prev_p) seen(flux_ok ? K_PON : K_POFF);
      if (head_en != prev_g) seen(head_en ? K_GON : K_GOFF);
    end
    prev_p = flux_ok;
    prev_g = head_en;
  end

  task automatic wait_to(input int c);
    while (pcnt < c) @(posedge clk);
    #2;
  endtask

  task automatic mark_now(output int m);
    @(posedge clk); #2;
    mark = 1'b1; m = pcnt + 1;
    @(posedge clk); #2;
    mark = 1'b0;
  endtask

  task automatic req_pulse();
    @(posedge clk); #2; req = 1'b1;
    @(posedge clk); #2; req = 1'b0;
  endtask

  task automatic stb_probe(input int exp, input string tag);
    @(posedge clk); #2; stb = 1'b1;
    @(posedge clk); #2; stb = 1'b0;
    @(negedge clk);
    chk(tag, int'(bit_go), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int m, m2, m3, m4, r;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 head_en in reset", int'(head_en), 0);
    chk("R1 flux_ok in reset", int'(flux_ok), 0);
    chk("R1 bit_go in reset",  int'(bit_go), 0);
    @(posedge clk); #2; rst = 1'b0;

    // R2: mark with nothing pending
    wait_to(pcnt + 20);
    mark_now(m);
    wait_to(m + L + 10);
    chk("R2 idle mark leaves gate low", int'(head_en), 0);
    wait_to(m + P);

    // R3 R4 R5 R6 R10: one written sector
    req_pulse();
    mark_now(m);
    expect_ev(K_GON, m + L, "R3 lead");
    expect_ev(K_PON, m + L + S, "R4 settle");
    wait_to(m + 100);
    stb_probe(0, "R10 strobe during lead");
    wait_to(m + L + S + 50);
    stb_probe(1, "R10 strobe while permitted");
    wait_to(m + P - 1);
    @(posedge clk); #2; mark = 1'b1; stb = 1'b1; m2 = pcnt + 1;
    expect_ev(K_POFF, m2, "R5 mark ends data");
    expect_ev(K_GOFF, m2 + T, "R6 trail");
    @(posedge clk); #2; mark = 1'b0; stb = 1'b0;
    @(negedge clk);
    chk("R10 strobe in mark cycle", int'(bit_go), 0);
    wait_to(m2 + T - 10);
    chk("R6 gate still on in trail", int'(head_en), 1);
    wait_to(m2 + P);

    // R7: request after a mark waits for the next one
    mark_now(m);
    wait_to(m + 200);
    req_pulse();
    wait_to(m + L + 20);
    chk("R7 late request held", int'(head_en), 0);
    wait_to(m + P - 1);
    mark_now(m2);
    expect_ev(K_GON, m2 + L, "R7 held request lead");
    expect_ev(K_PON, m2 + L + S, "R7 held request settle");

    // R8: request during write chains the next sector
    wait_to(m2 + L + S + 100);
    req_pulse();
    wait_to(m2 + P - 1);
    mark_now(m3);
    expect_ev(K_POFF, m3, "R5 mark ends chained data");
    expect_ev(K_PON, m3 + L + S, "R8 chained permit");
    wait_to(m3 + T + 10);
    chk("R8 gate held across boundary", int'(head_en), 1);
    chk("R8 permit off in chain lead", int'(flux_ok), 0);
    wait_to(m3 + P - 1);
    mark_now(m4);
    expect_ev(K_POFF, m4, "R5 mark ends second sector");
    expect_ev(K_GOFF, m4 + T, "R6 trail after chain");
    wait_to(m4 + P);

    // R9: mark inside the lead window restarts it
    req_pulse();
    mark_now(m);
    wait_to(m + 1000);
    mark_now(m2);
    expect_ev(K_GON, m2 + L, "R9 restarted lead");
    expect_ev(K_PON, m2 + L + S, "R9 settle after restart");
    wait_to(m2 + L + S + 100);

    // R1: reset while writing
    @(posedge clk); #2; rst = 1'b1; stb = 1'b1; r = pcnt + 1;
    expect_ev(K_POFF, r, "R1 reset drops permit");
    expect_ev(K_GOFF, r, "R1 reset drops gate");
    @(posedge clk); #2; rst = 1'b0; stb = 1'b0;
    @(negedge clk);
    chk("R1 bit_go after reset", int'(bit_go), 0);
    wait_to(r + 20);

    // R1: reset discards a pending request
    req_pulse();
    @(posedge clk); #2; rst = 1'b1;
    @(posedge clk); #2; rst = 1'b0;
    wait_to(pcnt + 10);
    mark_now(m);
    wait_to(m + L + 5);
    chk("R1 pending request discarded", int'(head_en), 0);
    wait_to(m + P);

    chk("scoreboard drained", exp_kind.size(), 0);
    finish_run();
  end
endmodule